// File: doc/BRIEF.md
# Dual-Clock Watchdog Timer

A watchdog timer split over two clock domains. Software reaches four word registers through a simple APB-style port on the bus clock: a mode register, a reload constant, a feed register and a read-only live count. The counting logic runs on a separate watchdog clock. A fixed divide-by-four prescaler drives a 24-bit down counter. When the counter runs out, the block raises either a timeout interrupt or a reset request, depending on the mode, and sets a sticky timeout flag.

Software first writes the reload constant and sets the enable bit. It then starts the counter, and later keeps it from expiring, by writing 0xAA and then 0x55 to the feed register. Mode and constant writes cross into the counting domain with a fixed three-cycle latency. The live count is copied back to the bus side through a request/acknowledge handshake, so a read never returns a value with bits from two different counts.

Top module: `wdt_dual_clk`

## Requirements
- R1: Once running, the counter loaded with value N underflows (N+1)*4 watchdog clock cycles after the load. It decrements by one on every fourth watchdog clock and reloads from the constant on underflow.
- R2: A constant write (offset 0x4, bits 23:0) below 0xFF stores 0xFF instead. Reading offset 0x4 returns the stored value, and the counter uses it.
- R3: A write of 0xAA followed directly by 0x55 to the feed register (offset 0x8, upper bits zero), with enable set, loads the counter from the constant and starts it. Repeating this in time keeps the timeout from occurring.
- R4: If any other bus write comes between 0xAA and 0x55, or the next feed byte is not 0x55, no reload happens. The sequence must start again from 0xAA.
- R5: Mode bit 0 (enable) and mode bit 1 (reset mode) at offset 0x0 can be set by software but not cleared. Writing zero to them leaves them set.
- R6: Underflow sets mode bit 2 (timeout flag). Only a mode write with bit 2 equal to zero clears the flag. A mode write with bit 2 set leaves the flag unchanged.
- R7: With reset mode off, `tmo_irq` is high exactly while the flag is set, one bus clock later, and `rst_req` stays low.
- R8: With reset mode on, `rst_req` is high exactly while the flag is set, one bus clock later, and `tmo_irq` stays low.
- R9: A mode or constant write is applied in the counting domain on the third watchdog clock edge after the bus write. A feed that follows uses the new constant.
- R10: Offset 0xC returns a coherent recent snapshot of the count. After reset, and before the first feed, it reads 0xFFFFFF.
- R11: After reset the mode register reads 0, the constant reads 0xFFFFFF, and both outputs are low.
- R12: Read data for the addressed register is valid during the access phase of a read, that is, while `psel` and `penable` are high and `pwrite` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst | input | 1 | Synchronous active-high reset, bus domain |
| wclk | input | 1 | Watchdog counting clock |
| wrst | input | 1 | Synchronous active-high reset, counting domain |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 4 | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, registered during the setup phase |
| rst_req | output | 1 | Reset request, registered |
| tmo_irq | output | 1 | Timeout interrupt, registered |

## Verification
The hardest situations to reach are the aborted feed sequences. The counter can only start through a feed, so an abort has no visible effect unless the bench can see that the count never left its reset value. The stimulus therefore sets enable and then tries two broken sequences before any valid feed: a wrong second byte, and a constant write placed between the two keys. After each attempt it reads the snapshot register and expects it still to read 0xFFFFFF. The expiry intervals are measured in watchdog clock cycles, from the feed write to the output edge, against windows derived from (N+1)*4 plus the synchronizer latency.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // word index of each register (address bits 3:2)
  localparam logic [1:0] REG_MODE  = 2'd0;
  localparam logic [1:0] REG_CONST = 2'd1;
  localparam logic [1:0] REG_FEED  = 2'd2;
  localparam logic [1:0] REG_COUNT = 2'd3;

  localparam logic [7:0] FEED_KEY1 = 8'hAA;
  localparam logic [7:0] FEED_KEY2 = 8'h55;
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/wdt_bus_regs.sv
module wdt_bus_regs
  import wdt_pkg::*;
#(
  parameter int          CNT_W    = 24,
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 4,
  parameter int unsigned MIN_LOAD = 255
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              uf_s,
  input  logic              ack_s,
  input  logic [CNT_W-1:0]  cnt_snap,
  output logic              cfg_tog,
  output logic              feed_tog,
  output logic              req_tog,
  output logic [CNT_W-1:0]  const_q,
  output logic              en_q,
  output logic              rst_en_q,
  output logic              tof_q,
  output logic              rst_req,
  output logic              tmo_irq
);
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_LOAD);

  logic [1:0]       sel;
  logic             aligned, wr_any, wr_mode, wr_const, key1, key2, hi_zero;
  logic             armed_q, uf_prev, uf_evt;
  logic [CNT_W-1:0] wr_cnt, const_in, cnt_rd;

  assign sel      = paddr[3:2];
  assign aligned  = (paddr[1:0] == 2'b00);
  assign wr_any   = psel && penable && pwrite;
  assign wr_mode  = wr_any && aligned && (sel == REG_MODE);
  assign wr_const = wr_any && aligned && (sel == REG_CONST);
  assign hi_zero  = (pwdata[DATA_W-1:8] == '0);
  assign key1     = wr_any && aligned && (sel == REG_FEED) && hi_zero && (pwdata[7:0] == FEED_KEY1);
  assign key2     = wr_any && aligned && (sel == REG_FEED) && hi_zero && (pwdata[7:0] == FEED_KEY2);
  assign wr_cnt   = pwdata[CNT_W-1:0];
  assign const_in = (wr_cnt < FLOOR) ? FLOOR : wr_cnt;
  assign uf_evt   = uf_s ^ uf_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      rst_en_q <= 1'b0;
      tof_q    <= 1'b0;
      const_q  <= '1;
      cfg_tog  <= 1'b0;
      feed_tog <= 1'b0;
      armed_q  <= 1'b0;
      uf_prev  <= 1'b0;
      rst_req  <= 1'b0;
      tmo_irq  <= 1'b0;
    end else begin
      uf_prev <= uf_s;
      if (wr_mode) begin
        en_q     <= en_q | pwdata[0];
        rst_en_q <= rst_en_q | pwdata[1];
        cfg_tog  <= ~cfg_tog;
      end
      if (wr_const) begin
        const_q <= const_in;
        cfg_tog <= ~cfg_tog;
      end
      // feed unlock: any write after the first key either completes or aborts
      if (wr_any) begin
        if (armed_q) begin
          armed_q <= 1'b0;
          if (key2 && en_q) feed_tog <= ~feed_tog;
        end else begin
          armed_q <= key1;
        end
      end
      if (uf_evt)                       tof_q <= 1'b1;
      else if (wr_mode && !pwdata[2])   tof_q <= 1'b0;
      rst_req <= tof_q && rst_en_q;
      tmo_irq <= tof_q && !rst_en_q;
    end
  end

  // count snapshot: request/acknowledge toggle pair
  always_ff @(posedge clk) begin
    if (rst) begin
      req_tog <= 1'b0;
      cnt_rd  <= '1;
    end else if (ack_s == req_tog) begin
      cnt_rd  <= cnt_snap;
      req_tog <= ~req_tog;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prdata <= '0;
    end else if (psel && !penable && !pwrite) begin
      unique case (sel)
        REG_MODE:  prdata <= DATA_W'({tof_q, rst_en_q, en_q});
        REG_CONST: prdata <= DATA_W'(const_q);
        REG_FEED:  prdata <= '0;
        default:   prdata <= DATA_W'(cnt_rd);
      endcase
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 24,
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_s,
  input  logic             feed_s,
  input  logic             req_s,
  input  logic [CNT_W-1:0] const_b,
  output logic             uf_tog,
  output logic             ack_tog,
  output logic [CNT_W-1:0] cnt_hold,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o,
  output logic             load_o
);
  logic [CNT_W-1:0] cnt_q, const_w, const_eff;
  logic [PRE_W-1:0] pre_q;
  logic             run_q, cfg_prev, feed_prev, cfg_evt, feed_evt, tick;

  assign cfg_evt   = cfg_s ^ cfg_prev;
  assign feed_evt  = feed_s ^ feed_prev;
  assign const_eff = cfg_evt ? const_b : const_w;
  assign tick      = run_q && (pre_q == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '1;
      const_w   <= '1;
      pre_q     <= '0;
      run_q     <= 1'b0;
      cfg_prev  <= 1'b0;
      feed_prev <= 1'b0;
      uf_tog    <= 1'b0;
    end else begin
      cfg_prev  <= cfg_s;
      feed_prev <= feed_s;
      if (cfg_evt) const_w <= const_b;
      if (feed_evt) begin
        run_q <= 1'b1;
        cnt_q <= const_eff;
        pre_q <= '0;
      end else if (run_q) begin
        pre_q <= pre_q + 1'b1;
        if (tick) begin
          if (cnt_q == '0) begin
            cnt_q  <= const_eff;
            uf_tog <= ~uf_tog;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_tog  <= 1'b0;
      cnt_hold <= '1;
    end else if (req_s != ack_tog) begin
      cnt_hold <= cnt_q;
      ack_tog  <= req_s;
    end
  end

  assign cnt_o  = cnt_q;
  assign tick_o = tick;
  assign load_o = feed_evt;
endmodule

// File: rtl/wdt_dual_clk.sv
module wdt_dual_clk #(
  parameter int          CNT_W    = 24,
  parameter int          PRE_W    = 2,
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 4,
  parameter int unsigned MIN_LOAD = 255,
  parameter int          SYNC_N   = 2
) (
  input  logic              bclk,
  input  logic              brst,
  input  logic              wclk,
  input  logic              wrst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              rst_req,
  output logic              tmo_irq
);
  logic             cfg_tog, feed_tog, req_tog, uf_tog, ack_tog;
  logic [2:0]       to_w;
  logic [1:0]       to_b;
  logic [CNT_W-1:0] const_b, cnt_hold, cnt_w;
  logic             en_b, rst_en_b, tof_b, tick_w, load_w;

  wdt_bus_regs #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MIN_LOAD(MIN_LOAD)
  ) u_regs (
    .clk(bclk), .rst(brst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .uf_s(to_b[0]), .ack_s(to_b[1]), .cnt_snap(cnt_hold),
    .cfg_tog(cfg_tog), .feed_tog(feed_tog), .req_tog(req_tog),
    .const_q(const_b), .en_q(en_b), .rst_en_q(rst_en_b), .tof_q(tof_b),
    .rst_req(rst_req), .tmo_irq(tmo_irq)
  );

  wdt_sync #(.W(3), .STAGES(SYNC_N)) u_sync_w (
    .clk(wclk), .rst(wrst), .d({req_tog, feed_tog, cfg_tog}), .q(to_w)
  );

  wdt_sync #(.W(2), .STAGES(SYNC_N)) u_sync_b (
    .clk(bclk), .rst(brst), .d({ack_tog, uf_tog}), .q(to_b)
  );

  wdt_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
    .clk(wclk), .rst(wrst), .cfg_s(to_w[0]), .feed_s(to_w[1]), .req_s(to_w[2]),
    .const_b(const_b), .uf_tog(uf_tog), .ack_tog(ack_tog), .cnt_hold(cnt_hold),
    .cnt_o(cnt_w), .tick_o(tick_w), .load_o(load_w)
  );
endmodule

// File: rtl/wdt_dual_clk_chk.sv
module wdt_dual_clk_chk #(
  parameter int          CNT_W    = 24,
  parameter int          ADDR_W   = 4,
  parameter int          DATA_W   = 32,
  parameter int unsigned MIN_LOAD = 255
) (
  input logic              bclk,
  input logic              brst,
  input logic              wclk,
  input logic              wrst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic              rst_req,
  input logic              tmo_irq,
  input logic              en_b,
  input logic              rst_en_b,
  input logic              tof_b,
  input logic [CNT_W-1:0]  cnt_w,
  input logic              tick_w,
  input logic              load_w
);
  logic clr_wr;
  assign clr_wr = psel && penable && pwrite && (paddr == '0) && !pwdata[2];

  // R5
  en_sticky_chk: assert property (@(posedge bclk) disable iff (brst) en_b |=> en_b);
  // R5
  rsten_sticky_chk: assert property (@(posedge bclk) disable iff (brst) rst_en_b |=> rst_en_b);
  // R6
  flag_hold_chk: assert property (@(posedge bclk) disable iff (brst) (tof_b && !clr_wr) |=> tof_b);
  // R7
  irq_follow_chk: assert property (@(posedge bclk) disable iff (brst) (tof_b && !rst_en_b) |=> (tmo_irq && !rst_req));
  // R8
  rst_follow_chk: assert property (@(posedge bclk) disable iff (brst) (tof_b && rst_en_b) |=> (rst_req && !tmo_irq));
  // R6
  quiet_chk: assert property (@(posedge bclk) disable iff (brst) !tof_b |=> (!tmo_irq && !rst_req));
  // R1
  step_chk: assert property (@(posedge wclk) disable iff (wrst)
    (tick_w && !load_w && cnt_w != '0) |=> (cnt_w == $past(cnt_w) - 1'b1));
  // R2
  floor_chk: assert property (@(posedge wclk) disable iff (wrst)
    (tick_w && !load_w && cnt_w == '0) |=> (cnt_w >= CNT_W'(MIN_LOAD)));
endmodule

bind wdt_dual_clk wdt_dual_clk_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_LOAD(MIN_LOAD)
) u_chk (
  .bclk(bclk), .brst(brst), .wclk(wclk), .wrst(wrst), .psel(psel),
  .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
  .rst_req(rst_req), .tmo_irq(tmo_irq), .en_b(en_b), .rst_en_b(rst_en_b),
  .tof_b(tof_b), .cnt_w(cnt_w), .tick_w(tick_w), .load_w(load_w)
);

// File: tb/sim_wdt_dual_clk.sv
module sim_wdt_dual_clk;
  logic        bclk = 0, wclk = 0, brst = 1, wrst = 1;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [3:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        rst_req, tmo_irq;

  int          checks = 0, errors = 0;
  int unsigned wcyc = 0;
  bit          sb_on = 0, done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 bclk = ~bclk;
  always #7 wclk = ~wclk;
  always @(posedge wclk) wcyc <= wcyc + 1;

  wdt_dual_clk u0 (
    .bclk(bclk), .brst(brst), .wclk(wclk), .wrst(wrst), .psel(psel),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .rst_req(rst_req), .tmo_irq(tmo_irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares read data in the access phase (R12)
  always @(negedge bclk) begin
    if (sb_on && psel && penable && !pwrite) begin
      if (exp_q.size() == 0) check(0, "R12 empty queue", prdata, 0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(prdata === e, t, prdata, e);
      end
    end
  end

  task automatic bus(input bit wr, input logic [3:0] a, input logic [31:0] d);
    @(posedge bclk); #2;
    psel = 1; pwrite = wr; penable = 0; paddr = a; pwdata = d;
    @(posedge bclk); #2;
    penable = 1;
    @(posedge bclk); #2;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus(1, a, d);
  endtask

  task automatic rd_exp(input logic [3:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    sb_on = 1;
    bus(0, a, '0);
    sb_on = 0;
  endtask

  task automatic rd_peek(input logic [3:0] a, output logic [31:0] v);
    @(posedge bclk); #2;
    psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(posedge bclk); #2;
    penable = 1;
    @(negedge bclk);
    v = prdata;
    @(posedge bclk); #2;
    psel = 0; penable = 0;
  endtask

  task automatic feed();
    wr(4'h8, 32'hAA);
    wr(4'h8, 32'h55);
  endtask

  task automatic wait_w(input int n);
    repeat (n) @(posedge wclk);
  endtask

  task automatic wait_out(input bit want_rst, output int dt);
    automatic int unsigned t0 = wcyc;
    automatic int n = 0;
    while (((want_rst ? rst_req : tmo_irq) !== 1'b1) && n < 8000) begin
      @(posedge wclk); n++;
    end
    dt = int'(wcyc - t0);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int dt;
    logic [31:0] v;
    repeat (10) @(posedge bclk);
    #2; brst = 0; wrst = 0;
    @(negedge bclk);
    // R11 reset state
    check(rst_req === 0 && tmo_irq === 0, "R11 outputs after reset", {rst_req, tmo_irq}, 0);
    rd_exp(4'h0, 32'h0, "R11 mode after reset");
    rd_exp(4'h4, 32'hFFFFFF, "R11 constant after reset");
    repeat (50) @(posedge bclk);
    rd_exp(4'hC, 32'hFFFFFF, "R10 count after reset");

    // R2 floor
    wr(4'h4, 32'h10);
    rd_exp(4'h4, 32'hFF, "R2 constant floored");

    // R5 sticky enable
    wr(4'h0, 32'h1);
    wr(4'h0, 32'h0);
    rd_exp(4'h0, 32'h1, "R5 enable not cleared");

    // R4 aborted feeds: wrong second byte, and interleaved write
    wr(4'h8, 32'hAA);
    wr(4'h8, 32'h54);
    repeat (100) @(posedge bclk);
    rd_exp(4'hC, 32'hFFFFFF, "R4 bad second key");
    wr(4'h8, 32'hAA);
    wr(4'h4, 32'h10);
    wr(4'h8, 32'h55);
    repeat (100) @(posedge bclk);
    rd_exp(4'hC, 32'hFFFFFF, "R4 interleaved write");

    // R3 / R1 first run with floored constant
    feed();
    wait_w(400);
    rd_peek(4'hC, v);
    check(v >= 32'h80 && v <= 32'hFF, "R10 mid-run snapshot in range", v, 32'hC0);
    check(tmo_irq === 0, "R3 no timeout early", tmo_irq, 0);
    wait_out(0, dt);
    dt = dt + 404;
    check(dt >= 1024 && dt <= 1045, "R1 R2 interval for 0xFF", dt, 1024);
    rd_exp(4'h0, 32'h5, "R6 flag set on underflow");
    check(rst_req === 0, "R7 no reset request", rst_req, 0);
    wait_w(1500);
    check(tmo_irq === 1, "R7 irq held until cleared", tmo_irq, 1);
    wr(4'h0, 32'h5);
    rd_exp(4'h0, 32'h5, "R6 write with bit2 set keeps flag");

    // R6 clear
    wr(4'h0, 32'h1);
    repeat (3) @(posedge bclk);
    @(negedge bclk);
    check(tmo_irq === 0, "R7 irq drops after clear", tmo_irq, 0);
    rd_exp(4'h0, 32'h1, "R6 flag cleared by write");

    // R3 keep alive
    feed();
    for (int i = 0; i < 5; i++) begin
      wait_w(700);
      check(tmo_irq === 0, "R3 fed watchdog stays quiet", tmo_irq, 0);
      feed();
    end
    rd_exp(4'h0, 32'h1, "R3 no flag while fed");

    // R9 new constant then feed
    wr(4'h4, 32'h200);
    feed();
    wait_out(0, dt);
    check(dt >= 2052 && dt <= 2070, "R9 R1 interval for 0x200", dt, 2052);
    wr(4'h0, 32'h1);

    // R8 reset mode
    wr(4'h0, 32'h3);
    feed();
    wait_out(1, dt);
    check(rst_req === 1 && dt >= 2052 && dt <= 2070, "R8 reset request timing", dt, 2052);
    check(tmo_irq === 0, "R8 no irq in reset mode", tmo_irq, 0);
    rd_exp(4'h0, 32'h7, "R8 mode reads reset mode and flag");
    wr(4'h0, 32'h3);
    repeat (3) @(posedge bclk);
    @(negedge bclk);
    check(rst_req === 0, "R8 request drops after clear", rst_req, 0);

    if (exp_q.size() != 0) check(0, "R12 unconsumed reads", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule